// File: doc/BRIEF.md
# Multi-Ratio Clock Divider Bank

The bank turns one reference clock into eight derived clocks, all running at the same time. Each output has its own divider unit. The top level only instantiates these units and gives them the shared clock and an active-low asynchronous reset. Each unit is described by one parameter: its output period counted in reference half-cycles.

The parity of that number picks the circuit for the unit:

- **Even integer ratio:** a plain rising-edge divider.
- **Odd integer ratio:** a rising-edge window ORed with a copy retimed on the falling edge, which gives 50% duty.
- **Half-integer ratio (such as 2.5):** one rising-edge counter covers two output periods, and a falling-edge window decoder places every second pulse on a falling edge.

With the default set and a 10 kHz reference, the outputs are 200 Hz, 400 Hz, 250 Hz, 500 Hz, 625 Hz, 2 kHz, 4 kHz and 5 kHz. All outputs leave reset low and rise together on the first reference rising edge after reset is released. This gives a known common phase.

Top module: `ratio_clock_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `div_clk` is 0. Asserting `rst_n` clears the outputs at once, without waiting for a clock edge.
- R2: Bit i of `div_clk` has a period of `HALF_RATIO[i]` reference half-cycles. The default list, from bit 0 to bit 7, is 100, 50, 80, 40, 32, 10, 5, 4. These are divide ratios of 50, 25, 40, 20, 16, 5, 2.5 and 2.
- R3: An output whose half-cycle count is a multiple of 4 (an even integer ratio N) repeats every N reference cycles. It is high for exactly N/2 of those cycles.
- R4: An output whose half-cycle count is twice an odd number (an odd integer ratio N) repeats every N reference cycles. It is high for exactly N reference half-cycles, which is 50% duty.
- R5: An output with an odd half-cycle count H repeats every H half-cycles and is high for (H-1)/2 of them. H must be 1 more than a multiple of 4 and at least 5; for H=5 the output is high 2 half-cycles and low 3. Successive pulses start alternately on a rising and a falling reference edge.
- R6: After reset is released, no output changes before the first reference rising edge. At that edge every output goes high. Counting half-cycles k from that edge, output i is high exactly when (k mod `HALF_RATIO[i]`) < `HALF_RATIO[i]`/2, using integer division.
- R7: Asserting reset in the middle of a run and releasing it again brings all outputs back to the common phase of R6, whatever phase they had before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_clk | output | NUM_OUT | Divided clocks, one bit per divider unit |

## Verification
The assertions run on every cycle and check three things:
- Each internal phase counter stays below its period.
- The rising-edge window of each unit rises once every period, and it rises on the first edge after reset.
- In half-integer units, the rising and falling windows never overlap.

Duty cycle, the exact half-cycle placement of every output edge, the quiet interval between reset release and the first rising edge, and the asynchronous clear can only be shown at the ports. The bench's scenarios cover these. It releases reset both while the clock is high and while it is low, and it applies resets in the middle of a run. It then compares every output in every half-cycle against the model in R6.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        KIND_EVEN,   // period in half-cycles divisible by 4
        KIND_ODD,    // period in half-cycles is 2 * odd
        KIND_HALF    // period in half-cycles is odd (half-integer ratio)
    } div_kind_e;

    function automatic div_kind_e kind_of(input int unsigned half_ratio);
        if ((half_ratio % 2) != 0)            return KIND_HALF;
        else if (((half_ratio / 2) % 2) != 0) return KIND_ODD;
        else                                  return KIND_EVEN;
    endfunction

    // Number of rising edges after which the rising-edge counter wraps.
    function automatic int unsigned rise_period(input int unsigned half_ratio);
        if ((half_ratio % 2) != 0) return half_ratio;      // spans two output periods
        else                       return half_ratio / 2;  // one output period
    endfunction

    function automatic int unsigned width_for(input int unsigned count);
        if (count <= 2) return 1;
        else            return $clog2(count);
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
    parameter int unsigned PERIOD = 5,
    localparam int unsigned CW    = clkdiv_pkg::width_for(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (int'(st_q.cnt) == int'(PERIOD) - 1) st_d.cnt = '0;
        else                                     st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2: the phase counter never reaches the period length
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < int'(PERIOD));

endmodule

// File: rtl/clkdiv_unit.sv
`timescale 1ns/1ps
module clkdiv_unit
    import clkdiv_pkg::*;
#(
    parameter int unsigned HALF_RATIO = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_out
);

    localparam div_kind_e   KIND = kind_of(HALF_RATIO);
    localparam int unsigned P    = rise_period(HALF_RATIO);
    localparam int unsigned CW   = width_for(P);
    localparam int unsigned GW   = CW + 2;
    // Length of the rising-edge window, counted in rising edges.
    localparam int unsigned RISE_LEN =
        (KIND == KIND_EVEN) ? P / 2 :
        (KIND == KIND_ODD)  ? (P - 1) / 2 :
                              (P - 1) / 4;
    // Falling-edge window of the half-integer variant: the second pulse.
    localparam int unsigned FALL_START = (P + 1) / 2;
    localparam int unsigned FALL_LEN   = (P - 1) / 4;

    logic [CW-1:0] cnt_q;

    clkdiv_counter #(.PERIOD(P)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_q)
    );

    typedef struct packed {
        logic rise;
    } rise_state_t;

    rise_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = int'(cnt_q) < int'(RISE_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (KIND == KIND_EVEN) begin : g_even
            assign clk_out = st_q.rise;
        end else begin : g_dual
            logic fall_d, fall_q;

            always_comb begin
                if (KIND == KIND_ODD)
                    fall_d = st_q.rise;   // half-cycle delayed copy widens the pulse
                else
                    fall_d = (int'(cnt_q) >= int'(FALL_START)) &&
                             (int'(cnt_q) <  int'(FALL_START + FALL_LEN));
            end

            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) fall_q <= 1'b0;
                else        fall_q <= fall_d;
            end

            assign clk_out = st_q.rise | fall_q;

            if (KIND == KIND_HALF) begin : g_half_chk
                // R5: the two pulses of a half-integer unit never overlap
                a_r5_half_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
                    !(st_q.rise && fall_q));
            end
        end
    endgenerate

    // Checker: rising edges since the rising-edge window last opened.
    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          opens;

    assign opens = st_d.rise && !st_q.rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (opens) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R6: the window opens on the very first rising edge after reset
    a_r6_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> st_d.rise);

    // R3: successive openings are exactly one counter period apart
    a_r3_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (opens && seen_q) |-> (gap_q == GW'(P)));

endmodule

// File: rtl/ratio_clock_bank.sv
`timescale 1ns/1ps
module ratio_clock_bank #(
    parameter int unsigned NUM_OUT = 8,
    parameter int unsigned HALF_RATIO [NUM_OUT] = '{100, 50, 80, 40, 32, 10, 5, 4}
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    output logic [NUM_OUT-1:0] div_clk
);

    generate
        for (genvar gi = 0; gi < int'(NUM_OUT); gi++) begin : g_unit
            clkdiv_unit #(.HALF_RATIO(HALF_RATIO[gi])) u_div (
                .clk     (ref_clk),
                .rst_n   (rst_n),
                .clk_out (div_clk[gi])
            );
        end
    endgenerate

endmodule

// File: tb/sim_ratio_clock_bank.sv
`timescale 1ns/1ps
module sim_ratio_clock_bank;

    localparam int NOUT = 8;
    localparam int HR [NOUT] = '{100, 50, 80, 40, 32, 10, 5, 4};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NOUT-1:0] div_clk;
    int              checks = 0;
    int              fails  = 0;
    bit              done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ratio_clock_bank u0 (
        .ref_clk (ref_clk_w),
        .rst_n   (rst_n),
        .div_clk (div_clk)
    );
    wire ref_clk_w = clk;

    // Model of R6: high while (k mod H) < H/2
    function automatic bit exp_bit(input int h, input int k);
        return (k % h) < (h / 2);
    endfunction

    function automatic string req_of(input int h, input int k);
        if (k < h)                return "R6";
        if ((h % 2) != 0)         return "R2/R5";
        if (((h / 2) % 2) != 0)   return "R2/R4";
        return "R2/R3";
    endfunction

    task automatic check_all_low(input string req);
        checks++;
        if (div_clk !== '0) begin
            fails++;
            $display("FAIL %s: outputs actual=%b expected=%b at %0t", req, div_clk, {NOUT{1'b0}}, $time);
        end
    endtask

    task automatic check_half(input int k);
        for (int i = 0; i < NOUT; i++) begin
            bit e;
            e = exp_bit(HR[i], k);
            checks++;
            if (div_clk[i] !== e) begin
                fails++;
                $display("FAIL %s: bit %0d half-cycle %0d actual=%b expected=%b",
                         req_of(HR[i], k), i, k, div_clk[i], e);
            end
        end
    endtask

    // Release reset off an edge; off is the ns after a rising edge (not 0 or 4).
    task automatic release_reset(input int off);
        @(posedge clk);
        #(off);
        rst_n = 1'b1;
        #(8 - off - 1);
        check_all_low("R6");   // nothing moves before the first rising edge
    endtask

    task automatic run_halves(input int n);
        for (int k = 0; k < n; k += 2) begin
            @(posedge clk); #2; check_half(k);
            @(negedge clk); #2; check_half(k + 1);
        end
    endtask

    // Ends at negedge+2: assert reset and look 1 ns later, before any edge.
    task automatic mid_reset(input int hold);
        rst_n = 1'b0;
        #1;
        check_all_low("R1/R7");
        repeat (hold) @(posedge clk);
        #2;
        check_all_low("R1");
    endtask

    initial begin
        int unsigned seed;
        int offs [6] = '{1, 2, 3, 5, 6, 7};
        seed = $urandom(32'h5EED_0042);
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check_all_low("R1");
        // Directed: release while clock high (falling edge precedes first rise)
        release_reset(2);
        run_halves(420);          // four full periods of the slowest output
        mid_reset(3);             // R7
        // Directed: release while clock low
        release_reset(6);
        run_halves(210);
        mid_reset(1);
        // Random segments with R7 resets at arbitrary phases
        for (int s = 0; s < 5; s++) begin
            int off, n;
            off = offs[$urandom % 6];
            n   = 2 * (60 + int'($urandom % 150));
            release_reset(off);
            run_halves(n);
            mid_reset(1 + int'($urandom % 4));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule